// File: doc/BRIEF.md
# Segmented 20-bit Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical byte address. The segment is scaled by sixteen and the offset is added. Any carry out of the top address bit is dropped, so the result wraps inside a 1 MB space. Each accepted request is either a data access or an instruction fetch. A data access uses the offset given on `off`. A fetch uses an internal instruction pointer as the offset, and that pointer then moves forward by the instruction length the caller supplies.

Every access reads one or two bytes from a byte-wide synchronous memory with one cycle of read latency. A word is assembled little-endian: the byte at the lower address becomes the low half. A byte is steered into either the low or the high half of a 16-bit destination register, and the other half keeps its value. A single-cycle `dataValid` pulse marks the cycle in which the new register value is on `regOut`.

Top module: `segAddrGen`

## Requirements
- R1: After reset, `physAddr`, `ipOut` and `regOut` are zero and `dataValid` is low.
- R2: A data request (`reqIsFetch`=0) accepted while idle places `({seg,4'h0} + off) mod 2^20` on `physAddr` from the cycle after acceptance. For example, FFFF:FFFF gives 0FFEF.
- R3: A fetch request (`reqIsFetch`=1) takes `seg` as the code segment and the instruction pointer value held before acceptance as the offset. The `off` input is ignored for a fetch.
- R4: An accepted fetch adds `fetchLen` (0 to 7) to the instruction pointer on the acceptance edge, modulo 2^16. `ipLoad`=1 loads `ipLoadVal` on the next edge, and a load wins over a fetch advance at the same edge.
- R5: A word read (`isWord`=1) sets `regOut` to `{mem[a+1], mem[a]}`, where `a` is the physical address. `laneHigh` has no effect on a word read.
- R6: A byte read (`isWord`=0) writes `mem[a]` into bits 7:0 when `laneHigh`=0 and into bits 15:8 when `laneHigh`=1. The other half of `regOut` is left unchanged.
- R7: The second byte of a word read is fetched from `(a+1) mod 2^20`, so a word at FFFFF takes its high byte from 00000.
- R8: `dataValid` is a one-cycle pulse. It rises two clock edges after the acceptance edge for a byte read and three edges after it for a word read. `regOut` changes only at the edge that raises `dataValid`.
- R9: While an access is in progress, `reqValid` is ignored. `physAddr`, the instruction pointer and the result all stay as the first request set them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start an access (taken only when idle) |
| reqIsFetch | input | 1 | 1 = instruction fetch at seg:IP, 0 = data access at seg:off |
| seg | input | 16 | Segment value |
| off | input | 16 | Data offset (ignored for a fetch) |
| isWord | input | 1 | 1 = two-byte read, 0 = one-byte read |
| laneHigh | input | 1 | Byte read target: 1 = bits 15:8, 0 = bits 7:0 |
| fetchLen | input | 3 | Instruction length added to IP on a fetch |
| ipLoad | input | 1 | Load the instruction pointer |
| ipLoadVal | input | 16 | Value for an IP load |
| memAddr | output | 20 | Byte address to the synchronous memory |
| memRdata | input | 8 | Read byte, valid one cycle after memAddr |
| physAddr | output | 20 | Physical address of the current or last access |
| ipOut | output | 16 | Instruction pointer |
| regOut | output | 16 | Destination register |
| dataValid | output | 1 | One-cycle pulse: regOut holds a new result |

## Verification
The assertions check on every cycle the properties that have a fixed shape. These are the single-cycle `dataValid` pulse and the hold of `regOut` between pulses. They also cover the address formed for a data request, the pointer advance or load, the +1 (wrapping) address used for the second byte of a word, and the steadiness of `physAddr` while an access is in progress. Only the bench's scenarios can show the byte values read and the lane that receives a byte. The same holds for the preserved opposite half, the exact latency and the wrap cases at FFFF:FFFF, at FFFFF and at IP FFFF. Those scenarios also confirm that a request during an access leaves every output undisturbed.

// File: rtl/segPkg.sv
`timescale 1ns/1ps
package segPkg;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic latchReq;    // idle and a request present: capture address and lane
    logic selHigh;     // memory address = captured address + 1
    logic capLow;      // keep the first byte returned
    logic commitByte;  // write one byte into the selected half
    logic commitWord;  // write both halves
  } segCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_CAP0  = 2'd2,
    ST_CAP1  = 2'd3
  } segState_t;

endpackage

// File: rtl/segAddrCalc.sv
`timescale 1ns/1ps
module segAddrCalc #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int PA_W  = 20,
  parameter int SHIFT = 4
) (
  input  logic [SEG_W-1:0] segIn,
  input  logic [OFF_W-1:0] offIn,
  output logic [PA_W-1:0]  physOut
);
  localparam int BASE_W = SEG_W + SHIFT;

  logic [BASE_W-1:0] baseAddr;

  assign baseAddr = {segIn, {SHIFT{1'b0}}};
  // Carry beyond the top physical bit is discarded: modulo 2^PA_W.
  assign physOut  = PA_W'(baseAddr) + PA_W'(offIn);

endmodule

// File: rtl/segControl.sv
`timescale 1ns/1ps
module segControl
  import segPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     isWord,
  output segCtrl_t ctrl,
  output logic     idle
);
  segState_t state, stateNext;
  logic      wordReg;

  always_comb begin
    ctrl      = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        ctrl.latchReq = reqValid;
        if (reqValid) stateNext = ST_ISSUE;
      end
      ST_ISSUE: stateNext = ST_CAP0;
      ST_CAP0: begin
        ctrl.capLow     = 1'b1;
        ctrl.selHigh    = wordReg;
        ctrl.commitByte = !wordReg;
        stateNext       = wordReg ? ST_CAP1 : ST_IDLE;
      end
      ST_CAP1: begin
        ctrl.commitWord = 1'b1;
        stateNext       = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordReg <= 1'b0;
    end else begin
      state <= stateNext;
      if (ctrl.latchReq) wordReg <= isWord;
    end
  end

  assign idle = (state == ST_IDLE);

endmodule

// File: rtl/segDatapath.sv
`timescale 1ns/1ps
module segDatapath
  import segPkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int PA_W   = 20,
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  segCtrl_t          ctrl,
  input  logic              reqIsFetch,
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  input  logic              laneHigh,
  input  logic [LEN_W-1:0]  fetchLen,
  input  logic              ipLoad,
  input  logic [OFF_W-1:0]  ipLoadVal,
  input  logic [BYTE_W-1:0] memRdata,
  output logic [PA_W-1:0]   memAddr,
  output logic [PA_W-1:0]   physAddr,
  output logic [OFF_W-1:0]  ipOut,
  output logic [2*BYTE_W-1:0] regOut,
  output logic              dataValid
);
  localparam int DATA_W = 2 * BYTE_W;

  logic [OFF_W-1:0]  ipReg;
  logic [OFF_W-1:0]  offSel;
  logic [PA_W-1:0]   physNext;
  logic [PA_W-1:0]   addrReg;
  logic              laneReg;
  logic [BYTE_W-1:0] lowByte;
  logic [DATA_W-1:0] regNext;

  assign offSel = reqIsFetch ? ipReg : off;

  segAddrCalc #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .SHIFT(4)
  ) i_calc (
    .segIn  (seg),
    .offIn  (offSel),
    .physOut(physNext)
  );

  // Second byte of a word wraps inside the physical space.
  assign memAddr = ctrl.selHigh ? (addrReg + PA_W'(1)) : addrReg;

  always_comb begin
    regNext = regOut;
    if (ctrl.commitWord)
      regNext = {memRdata, lowByte};
    else if (ctrl.commitByte) begin
      if (laneReg) regNext = {memRdata, regOut[BYTE_W-1:0]};
      else         regNext = {regOut[DATA_W-1:BYTE_W], memRdata};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ipReg     <= '0;
      addrReg   <= '0;
      laneReg   <= 1'b0;
      lowByte   <= '0;
      regOut    <= '0;
      dataValid <= 1'b0;
    end else begin
      if (ipLoad)
        ipReg <= ipLoadVal;
      else if (ctrl.latchReq && reqIsFetch)
        ipReg <= ipReg + OFF_W'(fetchLen);
      if (ctrl.latchReq) begin
        addrReg <= physNext;
        laneReg <= laneHigh;
      end
      if (ctrl.capLow) lowByte <= memRdata;
      regOut    <= regNext;
      dataValid <= ctrl.commitByte | ctrl.commitWord;
    end
  end

  assign physAddr = addrReg;
  assign ipOut    = ipReg;

endmodule

// File: rtl/segAddrGen.sv
`timescale 1ns/1ps
module segAddrGen
  import segPkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int PA_W   = 20,
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqIsFetch,
  input  logic [SEG_W-1:0]    seg,
  input  logic [OFF_W-1:0]    off,
  input  logic                isWord,
  input  logic                laneHigh,
  input  logic [LEN_W-1:0]    fetchLen,
  input  logic                ipLoad,
  input  logic [OFF_W-1:0]    ipLoadVal,
  output logic [PA_W-1:0]     memAddr,
  input  logic [BYTE_W-1:0]   memRdata,
  output logic [PA_W-1:0]     physAddr,
  output logic [OFF_W-1:0]    ipOut,
  output logic [2*BYTE_W-1:0] regOut,
  output logic                dataValid
);
  segCtrl_t ctrl;
  logic     idle;

  segControl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .isWord  (isWord),
    .ctrl    (ctrl),
    .idle    (idle)
  );

  segDatapath #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .BYTE_W(BYTE_W), .LEN_W(LEN_W)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .reqIsFetch(reqIsFetch),
    .seg       (seg),
    .off       (off),
    .laneHigh  (laneHigh),
    .fetchLen  (fetchLen),
    .ipLoad    (ipLoad),
    .ipLoadVal (ipLoadVal),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .physAddr  (physAddr),
    .ipOut     (ipOut),
    .regOut    (regOut),
    .dataValid (dataValid)
  );

endmodule

// File: rtl/segAddrGenChk.sv
`timescale 1ns/1ps
module segAddrGenChk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqIsFetch,
  input logic [15:0] seg,
  input logic [15:0] off,
  input logic [2:0]  fetchLen,
  input logic        ipLoad,
  input logic [15:0] ipLoadVal,
  input logic [19:0] memAddr,
  input logic [19:0] physAddr,
  input logic [15:0] ipOut,
  input logic [15:0] regOut,
  input logic        dataValid,
  input logic        idle,
  input logic        secondByte
);

  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  a_r8_reg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |-> $stable(regOut));

  a_r2_data_addr: assert property (@(posedge clk) disable iff (!rstN)
    (idle && reqValid && !reqIsFetch) |=>
      physAddr == (20'({$past(seg), 4'h0}) + 20'($past(off))));

  a_r4_ip_advance: assert property (@(posedge clk) disable iff (!rstN)
    (idle && reqValid && reqIsFetch && !ipLoad) |=>
      ipOut == $past(ipOut) + 16'($past(fetchLen)));

  a_r4_ip_load: assert property (@(posedge clk) disable iff (!rstN)
    ipLoad |=> ipOut == $past(ipLoadVal));

  a_r7_second_byte: assert property (@(posedge clk) disable iff (!rstN)
    secondByte |-> memAddr == physAddr + 20'd1);

  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    !idle |=> $stable(physAddr));

endmodule

bind segAddrGen segAddrGenChk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqIsFetch(reqIsFetch),
  .seg       (seg),
  .off       (off),
  .fetchLen  (fetchLen),
  .ipLoad    (ipLoad),
  .ipLoadVal (ipLoadVal),
  .memAddr   (memAddr),
  .physAddr  (physAddr),
  .ipOut     (ipOut),
  .regOut    (regOut),
  .dataValid (dataValid),
  .idle      (idle),
  .secondByte(ctrl.selHigh)
);

// File: tb/test_segAddrGen.sv
`timescale 1ns/1ps
module test_segAddrGen;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqIsFetch, isWord, laneHigh, ipLoad;
  logic [15:0] seg, off, ipLoadVal;
  logic [2:0]  fetchLen;
  logic [19:0] memAddr, physAddr;
  logic [7:0]  memRdata;
  logic [15:0] ipOut, regOut;
  logic        dataValid;

  int checks = 0;
  int fails  = 0;
  logic [15:0] expIp  = 16'h0;
  logic [15:0] expReg = 16'h0;
  bit          doneRun = 1'b0;

  always #5 clk = ~clk;

  segAddrGen i_segAddrGen (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsFetch(reqIsFetch),
    .seg(seg), .off(off), .isWord(isWord), .laneHigh(laneHigh),
    .fetchLen(fetchLen), .ipLoad(ipLoad), .ipLoadVal(ipLoadVal),
    .memAddr(memAddr), .memRdata(memRdata), .physAddr(physAddr),
    .ipOut(ipOut), .regOut(regOut), .dataValid(dataValid)
  );

  // Computed memory contents: distinct at 00000 (A5) and FFFFF (AA).
  function automatic logic [7:0] memByte(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'hA5;
  endfunction

  function automatic logic [19:0] expPhys(input logic [15:0] s, input logic [15:0] o);
    logic [20:0] full;
    full = {1'b0, s, 4'h0} + {5'h0, o};
    return full[19:0];
  endfunction

  always @(posedge clk) memRdata <= memByte(memAddr);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic setIp(input logic [15:0] v);
    @(negedge clk);
    ipLoad = 1'b1; ipLoadVal = v;
    @(posedge clk);
    @(negedge clk);
    ipLoad = 1'b0;
    expIp = v;
    chk(ipOut == expIp, "R4", "ip load", 32'(ipOut), 32'(expIp));
  endtask

  task automatic doAcc(input bit fetch, input logic [15:0] s, input logic [15:0] o,
                       input bit w, input bit hi, input logic [2:0] len, input bit junk);
    logic [15:0] exOff;
    logic [19:0] exPa;
    logic [7:0]  b0, b1;
    int n;
    exOff = fetch ? expIp : o;
    exPa  = expPhys(s, exOff);
    @(negedge clk);
    reqValid = 1'b1; reqIsFetch = fetch; seg = s; off = o;
    isWord = w; laneHigh = hi; fetchLen = len;
    @(posedge clk);
    @(negedge clk);
    if (fetch) expIp = expIp + 16'(len);
    reqValid = junk;
    if (junk) begin
      seg = ~s; off = ~o; reqIsFetch = 1'b1; fetchLen = 3'd7; isWord = ~w; laneHigh = ~hi;
    end
    chk(physAddr == exPa, fetch ? "R3" : "R2", "physical address", 32'(physAddr), 32'(exPa));
    chk(ipOut == expIp, "R4", "ip after request", 32'(ipOut), 32'(expIp));
    n = 0;
    while (!dataValid && n < 12) begin
      @(posedge clk);
      @(negedge clk);
      reqValid = 1'b0;
      n++;
    end
    chk(n == (w ? 3 : 2), "R8", "latency", 32'(n), w ? 32'd3 : 32'd2);
    b0 = memByte(exPa);
    b1 = memByte(exPa + 20'd1);
    if (w)       expReg = {b1, b0};
    else if (hi) expReg = {b0, expReg[7:0]};
    else         expReg = {expReg[15:8], b0};
    chk(regOut == expReg, w ? "R5" : "R6", "register", 32'(regOut), 32'(expReg));
    if (junk) begin
      chk(physAddr == exPa, "R9", "address during busy", 32'(physAddr), 32'(exPa));
      chk(ipOut == expIp, "R9", "ip during busy", 32'(ipOut), 32'(expIp));
    end
    @(posedge clk);
    @(negedge clk);
    chk(!dataValid, "R8", "pulse width", 32'(dataValid), 32'd0);
    chk(regOut == expReg, "R8", "register hold", 32'(regOut), 32'(expReg));
  endtask

  initial begin
    #1ms;
    if (!doneRun) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; reqValid = 0; reqIsFetch = 0; isWord = 0; laneHigh = 0;
    ipLoad = 0; ipLoadVal = 0; seg = 0; off = 0; fetchLen = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    chk(physAddr == 20'h0, "R1", "reset address", 32'(physAddr), 0);
    chk(ipOut == 16'h0, "R1", "reset ip", 32'(ipOut), 0);
    chk(regOut == 16'h0, "R1", "reset reg", 32'(regOut), 0);
    chk(!dataValid, "R1", "reset valid", 32'(dataValid), 0);

    // R5 word read, R6 byte lanes keep the other half
    doAcc(0, 16'h3000, 16'h0000, 1, 1, 3'd0, 0);
    doAcc(0, 16'h1234, 16'h0042, 0, 0, 3'd0, 0);
    doAcc(0, 16'h0777, 16'h9001, 0, 1, 3'd0, 0);
    // R2 wrap at top of space
    doAcc(0, 16'hFFFF, 16'hFFFF, 0, 0, 3'd0, 0);
    chk(physAddr == 20'h0FFEF, "R2", "FFFF:FFFF", 32'(physAddr), 32'h0FFEF);
    // R7 word straddling FFFFF -> 00000
    doAcc(0, 16'hF000, 16'hFFFF, 1, 0, 3'd0, 0);
    chk(regOut == 16'hA5AA, "R7", "wrapped word", 32'(regOut), 32'hA5AA);
    // R3/R4 fetch: 3-byte steps from 0
    setIp(16'h0000);
    doAcc(1, 16'h2000, 16'hBEEF, 0, 0, 3'd3, 0);
    doAcc(1, 16'h2000, 16'h1111, 1, 0, 3'd3, 0);
    chk(ipOut == 16'h0006, "R4", "two 3-byte fetches", 32'(ipOut), 32'h6);
    // R4 IP wrap
    setIp(16'hFFFE);
    doAcc(1, 16'h0100, 16'h0, 1, 1, 3'd5, 0);
    chk(ipOut == 16'h0003, "R4", "ip wrap", 32'(ipOut), 32'h3);
    // R4 load wins over advance
    @(negedge clk);
    ipLoad = 1; ipLoadVal = 16'h4000; reqValid = 1; reqIsFetch = 1; fetchLen = 3'd4;
    seg = 16'h0; isWord = 0; laneHigh = 0;
    @(posedge clk);
    @(negedge clk);
    ipLoad = 0; reqValid = 0;
    chk(ipOut == 16'h4000, "R4", "load priority", 32'(ipOut), 32'h4000);
    expIp = 16'h4000;
    expReg = {expReg[15:8], memByte(20'h00003)};
    repeat (3) @(negedge clk);
    chk(regOut == expReg, "R6", "byte after load race", 32'(regOut), 32'(expReg));
    // R9 requests during busy ignored
    doAcc(0, 16'h5555, 16'h0123, 1, 0, 3'd0, 1);
    doAcc(1, 16'h0ABC, 16'h0, 0, 1, 3'd2, 1);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 4'h0) setIp(16'($urandom));
      doAcc(r[4], 16'($urandom), 16'($urandom), r[5], r[6], 3'(r[9:7]), r[12:10] == 3'd0);
    end

    doneRun = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule